// File: doc/BRIEF.md
# Prime Population-Count Detector

This combinational block watches a vector of N single-bit lines and raises one output when the number of lines that are high is a prime. It does not rely on a stored list of primes. Its structure is the same for every N and it checks each candidate divisor.

One residue detector is built for every modulus K from 2 to N. Each detector flags when the population count is a multiple of its K. A count X with 2 ≤ X ≤ N is prime exactly when a single flag fires, the flag for K = X. Two upward compare-exchange passes lift the two largest flag values into two top lanes, and their XOR tells whether exactly one flag fired.

An all-low input makes every flag fire, so the result is also gated by an OR of all inputs. For N below 2 the output is tied low.

Top module: `prime_popcount_detect`

## Requirements
- R1: When the number of high bits on `in_i` is a prime (2, 3, 5, 7, 11 for the default N = 12), `prime_o` is high.
- R2: When the number of high bits is a composite value (4, 6, 8, 9, 10), `prime_o` is low.
- R3: When no bit of `in_i` is high, `prime_o` is low.
- R4: When exactly one bit of `in_i` is high, `prime_o` is low, whatever its position.
- R5: With every bit high, `prime_o` is high exactly when N is prime, so it is low for the default N = 12.
- R6: `prime_o` depends only on how many bits are high, not on which bits they are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_i | input | N | Lines whose high-bit count is tested |
| prime_o | output | 1 | High when that count is prime |

## Verification
The assertions assume that `in_i` holds a settled two-state value whenever the combinational checks are evaluated. The bench meets this by changing `in_i` only just after a falling clock edge and reading `prime_o` a nanosecond later. For the default width the stimulus covers every one of the 4096 input values. This makes the count-only dependence and the zero and one cases exhaustive rather than sampled.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
  // bits needed to hold a residue modulo k
  function automatic int res_width(input int k);
    return (k <= 2) ? 1 : $clog2(k);
  endfunction
endpackage

// File: rtl/ppd_mod_detect.sv
module ppd_mod_detect #(
  parameter int N = 12,
  parameter int K = 2
) (
  input  logic [N-1:0] bits_i,
  output logic         hit_o
);
  localparam int RW = ppd_pkg::res_width(K);
  localparam logic [RW-1:0] LAST = RW'(K - 1);

  logic [RW-1:0] res;

  // ripple residue modulo K through the lanes
  always_comb begin
    res = '0;
    for (int i = 0; i < N; i++) begin
      if (bits_i[i]) res = (res == LAST) ? '0 : res + RW'(1);
    end
    hit_o = (res == '0);
  end

  always_comb begin
    assert_mod_flag_R1: assert (hit_o == (($countones(bits_i) % K) == 0))
      else $error("divisor flag K=%0d wrong", K);
  end
endmodule

// File: rtl/ppd_bubble_up.sv
module ppd_bubble_up #(
  parameter int W = 4
) (
  input  logic [W-1:0] lanes_i,
  output logic         top_o,
  output logic [W-2:0] rest_o
);
  logic carry;

  // one upward pass: OR rises, AND stays behind
  always_comb begin
    carry = lanes_i[0];
    for (int i = 1; i < W; i++) begin
      rest_o[i-1] = carry & lanes_i[i];
      carry       = carry | lanes_i[i];
    end
    top_o = carry;
  end

  always_comb begin
    assert_pass_keeps_ones_R1: assert ($countones(lanes_i) == $countones({top_o, rest_o}))
      else $error("bubble pass changed count of ones");
    assert_pass_max_top_R1: assert (top_o == (lanes_i != '0))
      else $error("bubble pass lost its maximum");
  end
endmodule

// File: rtl/prime_popcount_detect.sv
module prime_popcount_detect #(
  parameter int N = 12
) (
  input  logic [N-1:0] in_i,
  output logic         prime_o
);
  localparam int FW = (N > 1) ? N - 1 : 1;

  if (N < 2) begin : g_tiny
    assign prime_o = 1'b0;
  end else begin : g_main
    logic [FW-1:0] flags;
    logic          any_hi;

    for (genvar k = 2; k <= N; k++) begin : g_div
      ppd_mod_detect #(.N(N), .K(k)) u_div (
        .bits_i (in_i),
        .hit_o  (flags[k-2])
      );
    end

    assign any_hi = |in_i;

    if (N == 2) begin : g_one_flag
      assign prime_o = flags[0] & any_hi;
    end else if (N == 3) begin : g_two_flags
      logic       top1;
      logic [0:0] rest1;
      ppd_bubble_up #(.W(2)) u_pass1 (.lanes_i(flags), .top_o(top1), .rest_o(rest1));
      assign prime_o = (top1 ^ rest1[0]) & any_hi;
    end else begin : g_two_pass
      logic          top1, top2;
      logic [FW-2:0] rest1;
      logic [FW-3:0] rest2;
      ppd_bubble_up #(.W(FW))   u_pass1 (.lanes_i(flags), .top_o(top1), .rest_o(rest1));
      ppd_bubble_up #(.W(FW-1)) u_pass2 (.lanes_i(rest1), .top_o(top2), .rest_o(rest2));
      // exactly one flag high <=> top high, second low
      assign prime_o = (top1 ^ top2) & any_hi;

      always_comb begin
        assert_flags_conserved_R1: assert ($countones(flags) ==
            32'(top1) + 32'(top2) + $countones(rest2))
          else $error("flag count not conserved across passes");
      end
    end

    always_comb begin
      assert_single_divisor_R1: assert (!prime_o || ($countones(flags) == 1))
        else $error("prime_o high without a single divisor flag");
      assert_zero_low_R3: assert (any_hi || !prime_o)
        else $error("prime_o high with no input set");
    end
  end

  always_comb begin
    assert_single_low_R4: assert (($countones(in_i) != 1) || !prime_o)
      else $error("prime_o high for a single set input");
  end
endmodule

// File: tb/prime_popcount_detect_tb.sv
module prime_popcount_detect_tb;
  localparam int N = 12;
  localparam int NV = 11;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] in_i = '0;
  logic         prime_o;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  prime_popcount_detect #(.N(N)) u_dut (.in_i(in_i), .prime_o(prime_o));

  // requirement codes: 1..6 map to R1..R6
  localparam logic [N-1:0] VEC [NV] = '{
    12'b000000000000, 12'b000000000001, 12'b100000000000, 12'b000000000011,
    12'b101000000000, 12'b000000000111, 12'b111100000000, 12'b000001111111,
    12'b000111111111, 12'b011111111111, 12'b111111111111};
  localparam bit EXP [NV] = '{0, 0, 0, 1, 1, 1, 0, 1, 0, 1, 0};
  localparam int REQ [NV] = '{3, 4, 4, 1, 1, 1, 2, 1, 2, 1, 5};

  function automatic string req_name(input int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic bit is_prime(input int x);
    if (x < 2) return 1'b0;
    for (int d = 2; d * d <= x; d++) if (x % d == 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic apply_check(input logic [N-1:0] v, input bit exp, input string req);
    @(negedge clk);
    in_i = v;
    #1;
    checks++;
    if (prime_o !== exp) begin
      errors++;
      $display("FAIL %s in=%b got=%b exp=%b", req, v, prime_o, exp);
    end
  endtask

  initial begin
    // reset state: inputs low, output low (R3)
    repeat (2) @(posedge clk);
    apply_check('0, 1'b0, "R3");
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) apply_check(VEC[i], EXP[i], req_name(REQ[i]));

    // R6: same count at every position gives same result
    for (int s = 0; s <= N - 5; s++) apply_check(N'(5'b11111) << s, 1'b1, "R6");
    for (int s = 0; s <= N - 6; s++) apply_check(N'(6'b111111) << s, 1'b0, "R6");

    // R4: single set bit at each position
    for (int s = 0; s < N; s++) apply_check(N'(1) << s, 1'b0, "R4");

    // exhaustive sweep against software primality
    for (int v = 0; v < (1 << N); v++) begin
      int c;
      string r;
      c = $countones(N'(v));
      if (c == 0) r = "R3";
      else if (c == 1) r = "R4";
      else if (c == N) r = "R5";
      else if (is_prime(c)) r = "R1";
      else r = "R2";
      apply_check(N'(v), is_prime(c), r);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired in=%b got=%b exp=done", in_i, prime_o);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule